// File: doc/BRIEF.md
# Shared Fetch/Data Memory Port Sequencer

This block lets a simple one-instruction-per-cycle processor use a single memory port for both instruction fetch and data access. Most instructions need only the fetch, and they finish in one cycle. A load or a store also needs a data access. The sequencer handles this by adding one cycle to that instruction. The first cycle fetches the instruction. The second cycle gives the port to the data address.

During the fetch cycle of a load or store, the machine is frozen. No state-changing write enable is raised, so the program counter, the register file and memory all keep their values. The fetched instruction word is captured into a holding register. In the second cycle the memory output carries load data, so the instruction word seen by the decoder comes from that holding register. The datapath, the ALU and the memory array are outside this block.

Top module: `shared_port_seq`

## Requirements
- R1: While `rst` is high at a rising edge, `rfWe`, `pcWe` and `memWe` are low, and `memAddr` equals `pcAddr`. The cycle after reset is released is a fetch cycle.
- R2: `classIn` encoding is 2'b00 = other, 2'b01 = load, 2'b10 = store. 2'b11 is treated exactly like other.
- R3: In a fetch cycle with a non-memory class, the instruction finishes in that cycle. `memAddr` = `pcAddr`, `pcWe` = 1, `rfWe` = `rfWrReq` and `memWe` = 0.
- R4: In a fetch cycle with a load or store class, all three write enables are low (stall), and the next cycle is a data cycle.
- R5: A data cycle lasts exactly one cycle. In it, `memAddr` = `dataAddr` and `pcWe` = 1, and the following cycle is a fetch cycle.
- R6: The data cycle of a load has `rfWe` = 1 and `memWe` = 0.
- R7: The data cycle of a store has `memWe` = 1 and `rfWe` = 0. `memWe` is never high outside a store's data cycle.
- R8: In a fetch cycle `instWord` equals `memRdata`. In a data cycle `instWord` equals the `memRdata` value from the preceding fetch cycle, whatever `memRdata` carries now.
- R9: During a data cycle, `classIn` and `rfWrReq` have no effect. The enables follow the class captured in the fetch cycle.
- R10: Memory instructions that follow each other back to back each get their own stall and data cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| classIn | input | 2 | Decoded class of the current instruction |
| rfWrReq | input | 1 | A non-memory instruction wants a register write |
| pcAddr | input | AW | Instruction fetch address |
| dataAddr | input | AW | Load/store address |
| memRdata | input | DW | Read data from the shared memory |
| memAddr | output | AW | Address driven onto the shared port |
| memWe | output | 1 | Memory write enable |
| instWord | output | DW | Instruction word for the decoder |
| rfWe | output | 1 | Gated register-file write enable |
| pcWe | output | 1 | Gated program-counter write enable |

## Verification
The embedded assertions check several properties on every cycle:
- the stall is quiet;
- a stall is always followed by exactly one data cycle, and the PC always advances in that data cycle;
- memory and register writes never coincide;
- a memory write only ever follows a fetched store;
- the instruction word shown in a data cycle is the one captured at the fetch.

Some behaviours can only be shown by the bench's scenarios, which compare the ports against a model built from the requirements:
- the address multiplexing against real address values;
- the treatment of the reserved class code;
- the garbage class and request inputs ignored during data cycles;
- reset arriving mid-instruction;
- back-to-back loads and stores.

// File: rtl/shared_port_pkg.sv
package shared_port_pkg;

  // Instruction class as decoded outside the block
  typedef enum logic [1:0] {
    CLS_OTHER = 2'b00,
    CLS_LOAD  = 2'b01,
    CLS_STORE = 2'b10,
    CLS_RSVD  = 2'b11
  } instClass_e;

  typedef enum logic {
    PH_FETCH = 1'b0,
    PH_DATA  = 1'b1
  } phase_e;

  // Strobes from the sequencing control to the address/instruction datapath
  typedef struct packed {
    logic selData;  // port carries the data address
    logic loadIr;   // capture the fetched word
    logic rfWe;
    logic pcWe;
    logic memWe;
  } strobe_t;

endpackage

// File: rtl/sps_control.sv
module sps_control
  import shared_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] classIn,
  input  logic       rfWrReq,
  output strobe_t    strobe
);

  phase_e     phase;
  phase_e     phaseNext;
  instClass_e heldClass;
  instClass_e curClass;
  logic       isMemOp;

  assign curClass = instClass_e'(classIn);
  assign isMemOp  = (curClass == CLS_LOAD) || (curClass == CLS_STORE);

  always_comb begin
    phaseNext = PH_FETCH;
    if (!rst) begin
      case (phase)
        PH_FETCH: phaseNext = isMemOp ? PH_DATA : PH_FETCH;
        PH_DATA:  phaseNext = PH_FETCH;
        default:  phaseNext = PH_FETCH;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_FETCH;
      heldClass <= CLS_OTHER;
    end else begin
      phase <= phaseNext;
      if (phase == PH_FETCH && isMemOp) begin
        heldClass <= curClass;
      end
    end
  end

  always_comb begin
    strobe = '0;
    if (!rst) begin
      case (phase)
        PH_FETCH: begin
          if (isMemOp) begin
            strobe.loadIr = 1'b1;
          end else begin
            strobe.pcWe = 1'b1;
            strobe.rfWe = rfWrReq;
          end
        end
        PH_DATA: begin
          strobe.selData = 1'b1;
          strobe.pcWe    = 1'b1;
          strobe.rfWe    = (heldClass == CLS_LOAD);
          strobe.memWe   = (heldClass == CLS_STORE);
        end
        default: strobe = '0;
      endcase
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |-> !(strobe.rfWe || strobe.pcWe || strobe.memWe)); // R1

  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FETCH && isMemOp) |-> !(strobe.rfWe || strobe.pcWe || strobe.memWe)); // R4

  AST_STALL_TO_DATA: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_FETCH && isMemOp) |=> strobe.selData); // R4

  AST_DATA_SINGLE: assert property (@(posedge clk) disable iff (rst)
    strobe.selData |=> !strobe.selData); // R5

  AST_DATA_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    strobe.selData |-> strobe.pcWe); // R5

  AST_NO_DUAL_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(strobe.memWe && strobe.rfWe)); // R6

  AST_STORE_ONLY_WRITE: assert property (@(posedge clk) disable iff (rst)
    strobe.memWe |-> (strobe.selData && $past(curClass) == CLS_STORE)); // R7

endmodule

// File: rtl/sps_datapath.sv
module sps_datapath
  import shared_port_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  strobe_t       strobe,
  input  logic [AW-1:0] pcAddr,
  input  logic [AW-1:0] dataAddr,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] instWord,
  output logic          memWe,
  output logic          rfWe,
  output logic          pcWe
);

  logic [DW-1:0] irQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      irQ <= '0;
    end else if (strobe.loadIr) begin
      irQ <= memRdata;
    end
  end

  assign memAddr  = strobe.selData ? dataAddr : pcAddr;
  assign instWord = strobe.selData ? irQ : memRdata;
  assign memWe    = strobe.memWe;
  assign rfWe     = strobe.rfWe;
  assign pcWe     = strobe.pcWe;

  AST_IR_HELD: assert property (@(posedge clk) disable iff (rst)
    (strobe.selData && $past(strobe.loadIr)) |-> instWord == $past(memRdata)); // R8

endmodule

// File: rtl/shared_port_seq.sv
module shared_port_seq
  import shared_port_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    classIn,
  input  logic          rfWrReq,
  input  logic [AW-1:0] pcAddr,
  input  logic [AW-1:0] dataAddr,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] memAddr,
  output logic          memWe,
  output logic [DW-1:0] instWord,
  output logic          rfWe,
  output logic          pcWe
);

  strobe_t strobe;

  sps_control u_control (
    .clk     (clk),
    .rst     (rst),
    .classIn (classIn),
    .rfWrReq (rfWrReq),
    .strobe  (strobe)
  );

  sps_datapath #(.AW(AW), .DW(DW)) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .pcAddr   (pcAddr),
    .dataAddr (dataAddr),
    .memRdata (memRdata),
    .memAddr  (memAddr),
    .instWord (instWord),
    .memWe    (memWe),
    .rfWe     (rfWe),
    .pcWe     (pcWe)
  );

endmodule

// File: tb/shared_port_seq_tb.sv
module shared_port_seq_tb;

  localparam int AW = 16;
  localparam int DW = 32;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic          memWe;
    logic          rfWe;
    logic          pcWe;
    logic [DW-1:0] inst;
  } expect_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    classIn = 2'b00;
  logic          rfWrReq = 1'b0;
  logic [AW-1:0] pcAddr = '0;
  logic [AW-1:0] dataAddr = '0;
  logic [DW-1:0] memRdata = '0;
  logic [AW-1:0] memAddr;
  logic          memWe;
  logic [DW-1:0] instWord;
  logic          rfWe;
  logic          pcWe;

  expect_t expQ[$];
  string   tagQ[$];
  int      checks = 0;
  int      fails = 0;
  bit      done = 1'b0;

  // Bench reference model state
  bit          mDataPhase = 1'b0;
  logic [1:0]  mClass = 2'b00;
  logic [DW-1:0] mIr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shared_port_seq #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst(rst), .classIn(classIn), .rfWrReq(rfWrReq),
    .pcAddr(pcAddr), .dataAddr(dataAddr), .memRdata(memRdata),
    .memAddr(memAddr), .memWe(memWe), .instWord(instWord),
    .rfWe(rfWe), .pcWe(pcWe)
  );

  // Driver: apply one cycle of inputs and push the expected outputs
  task automatic step(input logic r, input logic [1:0] c, input logic rq,
                      input logic [AW-1:0] pc, input logic [AW-1:0] da,
                      input logic [DW-1:0] rd, input string tag);
    expect_t e;
    bit isMem;
    @(posedge clk);
    #1;
    rst = r; classIn = c; rfWrReq = rq; pcAddr = pc; dataAddr = da; memRdata = rd;
    e = '0;
    isMem = (c == 2'b01) || (c == 2'b10);
    if (r) begin
      e.addr = pc; e.inst = rd;
      mDataPhase = 1'b0;
    end else if (!mDataPhase) begin
      e.addr = pc; e.inst = rd;
      if (isMem) begin
        mDataPhase = 1'b1; mClass = c; mIr = rd;
      end else begin
        e.pcWe = 1'b1; e.rfWe = rq;
      end
    end else begin
      e.addr = da; e.inst = mIr; e.pcWe = 1'b1;
      e.rfWe = (mClass == 2'b01);
      e.memWe = (mClass == 2'b10);
      mDataPhase = 1'b0;
    end
    expQ.push_back(e);
    tagQ.push_back(tag);
  endtask

  // Monitor: compare away from the active edge
  always @(negedge clk) begin
    if (expQ.size() != 0 && !done) begin
      expect_t e;
      expect_t got;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      got = '{addr: memAddr, memWe: memWe, rfWe: rfWe, pcWe: pcWe, inst: instWord};
      checks++;
      if (got !== e) begin
        fails++;
        $display("FAIL %s: got addr=%h memWe=%b rfWe=%b pcWe=%b inst=%h, expected addr=%h memWe=%b rfWe=%b pcWe=%b inst=%h",
                 t, got.addr, got.memWe, got.rfWe, got.pcWe, got.inst,
                 e.addr, e.memWe, e.rfWe, e.pcWe, e.inst);
      end
    end
  end

  initial begin
    // R1: reset state
    step(1'b1, 2'b00, 1'b1, 16'h0010, 16'h0200, 32'hAAAA0001, "R1 reset");
    step(1'b1, 2'b10, 1'b1, 16'h0011, 16'h0201, 32'hAAAA0002, "R1 reset store class");
    // R3: non-memory instructions, with and without register write
    step(1'b0, 2'b00, 1'b1, 16'h0100, 16'h0300, 32'h11110000, "R3 other rf write");
    step(1'b0, 2'b00, 1'b0, 16'h0101, 16'h0301, 32'h11110001, "R3 other no rf write");
    // R2: reserved code acts like other
    step(1'b0, 2'b11, 1'b1, 16'h0102, 16'h0302, 32'h11110002, "R2 reserved class");
    // R4, R5, R6, R8, R9: load, with garbage class/request in data cycle
    step(1'b0, 2'b01, 1'b0, 16'h0103, 16'h0400, 32'h22220001, "R4 load stall");
    step(1'b0, 2'b10, 1'b0, 16'h0103, 16'h0400, 32'hDEADBEEF, "R6 R8 R9 load data");
    // R7 R9: store, with load class and request during data cycle
    step(1'b0, 2'b10, 1'b1, 16'h0104, 16'h0500, 32'h33330001, "R4 store stall");
    step(1'b0, 2'b01, 1'b1, 16'h0104, 16'h0500, 32'hCAFEF00D, "R7 R9 store data");
    // R5: back to fetch after one data cycle
    step(1'b0, 2'b00, 1'b0, 16'h0105, 16'h0501, 32'h44440001, "R5 return to fetch");
    // R10: back-to-back load then store
    step(1'b0, 2'b01, 1'b1, 16'h0106, 16'h0600, 32'h55550001, "R10 load stall");
    step(1'b0, 2'b00, 1'b0, 16'h0106, 16'h0600, 32'h55550002, "R10 load data");
    step(1'b0, 2'b10, 1'b0, 16'h0107, 16'h0601, 32'h55550003, "R10 store stall");
    step(1'b0, 2'b11, 1'b0, 16'h0107, 16'h0601, 32'h55550004, "R10 store data");
    step(1'b0, 2'b10, 1'b0, 16'h0108, 16'h0602, 32'h55550005, "R10 store stall again");
    step(1'b0, 2'b00, 1'b1, 16'h0108, 16'h0602, 32'h55550006, "R10 store data again");
    // R1: reset arriving during a data cycle
    step(1'b0, 2'b01, 1'b0, 16'h0109, 16'h0700, 32'h66660001, "R4 load before reset");
    step(1'b1, 2'b01, 1'b1, 16'h0109, 16'h0700, 32'h66660002, "R1 reset in data cycle");
    step(1'b0, 2'b00, 1'b1, 16'h0000, 16'h0700, 32'h66660003, "R1 fetch after reset");
    // R8: fetch word passes through
    step(1'b0, 2'b00, 1'b0, 16'h0001, 16'h0701, 32'h77770001, "R8 fetch passthrough");
    @(posedge clk);
    @(negedge clk);
    #1;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule